// File: doc/BRIEF.md
# Pipeline Hazard Stall and Bubble Controller

This block sequences the five pipeline registers of an in-order processor with fetch, decode, execute, memory and write-back stages. It holds the fetch address register and the four stage registers that feed decode, execute, memory and write-back. From the stage contents and a few live datapath signals, it decides each cycle which registers load normally, which hold their value (stall), and which are overwritten with a no-operation entry (bubble). It also produces the enable that allows the execute stage to write the condition flags.

Four situations are handled. The first is a load whose result is needed at once by the instruction being decoded. The second is a return whose target address is not yet known. The third is a conditional jump that was predicted taken but is not taken. The fourth is an exceptional status that must freeze the tail of the pipe. Every stage entry is a packed word: `{status[2:0], icode[3:0], dst[3:0], data[DATA_W-1:0]}`, with status in the most significant bits. The surrounding datapath supplies the next entry for each register and reads back the registered entries.

Top module: `hz_pipe_ctrl`

## Requirements
- R1: Load/use. The execute entry holds a memory load (icode 5) or a pop (icode 11), and its dst is a real register (not 15) equal to `dec_src_a` or `dec_src_b`. Then `f_stall`, `d_stall` and `e_bubble` are 1.
- R2: A return (icode 9) in the decode, execute or memory entry sets `f_stall`. It also sets `d_bubble`, unless R1 holds.
- R3: A jump (icode 7) in the execute entry with `exe_cond` at 0 sets `d_bubble` and `e_bubble`. It does not by itself stall fetch.
- R4: When R1 and R2 hold together, the decode register stalls and is not bubbled: `d_stall`=1 and `d_bubble`=0.
- R5: Fault status codes are halt (2), address error (3) and invalid instruction (4). If `mem_stat` or the write-back status is a fault, `m_bubble` is 1 and `cc_write_en` is 0. A faulting write-back status also sets `w_stall`.
- R6: `cc_write_en` is 1 exactly when the execute icode is an arithmetic/logic operation (6) and R5 finds no fault.
- R7: A register whose stall input is 1 and whose bubble input is 0 keeps its value across the clock edge.
- R8: A register whose bubble input is 1 loads the empty entry: status 0, icode 1 (nop), dst 15, data 0.
- R9: A register with neither stall nor bubble loads its input entry.
- R10: While `rst_n` is low, all four stage registers hold the empty entry and `f_q` equals `RESET_PC`.
- R11: `out_stat` reports status 1 (OK) when the write-back status is 0 (empty). Otherwise it reports the write-back status unchanged.
- R12: No register ever has stall and bubble asserted in the same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| f_in | input | ADDR_W | Next predicted fetch address |
| f_q | output | ADDR_W | Registered fetch address |
| d_in | input | STAGE_W | Next decode entry |
| d_q | output | STAGE_W | Registered decode entry |
| e_in | input | STAGE_W | Next execute entry |
| e_q | output | STAGE_W | Registered execute entry |
| m_in | input | STAGE_W | Next memory entry |
| m_q | output | STAGE_W | Registered memory entry |
| w_in | input | STAGE_W | Next write-back entry |
| w_q | output | STAGE_W | Registered write-back entry |
| dec_src_a | input | 4 | First source register read in decode |
| dec_src_b | input | 4 | Second source register read in decode |
| exe_cond | input | 1 | Branch condition computed in execute |
| mem_stat | input | 3 | Live status out of the memory stage |
| f_stall | output | 1 | Fetch register hold |
| d_stall | output | 1 | Decode register hold |
| d_bubble | output | 1 | Decode register clear |
| e_bubble | output | 1 | Execute register clear |
| m_bubble | output | 1 | Memory register clear |
| w_stall | output | 1 | Write-back register hold |
| cc_write_en | output | 1 | Condition flag update allowed |
| out_stat | output | 3 | Externally reported status |

## Verification
The bench builds the block with `DATA_W`=16, `ADDR_W`=16 and `RESET_PC`=0x0100. A narrow data field keeps random entries cheap to compare. A nonzero reset address tells a reset apart from a load of zeros. Random register IDs are limited to 0..5 plus 15, so load/use matches, and the none-register exclusion of R1, come up often. Write-back faults are kept rare and the pipe is reset regularly. This lets the freeze in R5 be exercised without locking the pipe for the rest of the run.

// File: rtl/hz_pkg.sv
package hz_pkg;
  localparam int ST_W = 3;
  localparam int IC_W = 4;
  localparam int RG_W = 4;

  typedef logic [ST_W-1:0] stat_t;
  typedef logic [IC_W-1:0] icode_t;
  typedef logic [RG_W-1:0] reg_t;

  localparam stat_t ST_EMPTY = 3'd0;
  localparam stat_t ST_OK    = 3'd1;
  localparam stat_t ST_HALT  = 3'd2;
  localparam stat_t ST_ADDR  = 3'd3;
  localparam stat_t ST_ILL   = 3'd4;

  localparam icode_t IC_HALT  = 4'd0;
  localparam icode_t IC_NOP   = 4'd1;
  localparam icode_t IC_MOVE  = 4'd2;
  localparam icode_t IC_IMM   = 4'd3;
  localparam icode_t IC_STORE = 4'd4;
  localparam icode_t IC_LOAD  = 4'd5;
  localparam icode_t IC_ALU   = 4'd6;
  localparam icode_t IC_JUMP  = 4'd7;
  localparam icode_t IC_CALL  = 4'd8;
  localparam icode_t IC_RET   = 4'd9;
  localparam icode_t IC_PUSH  = 4'd10;
  localparam icode_t IC_POP   = 4'd11;

  localparam reg_t REG_NONE = 4'd15;

  // Status values that freeze the tail of the pipe.
  function automatic logic is_fault(input stat_t s);
    return (s == ST_HALT) || (s == ST_ADDR) || (s == ST_ILL);
  endfunction

  // Instructions whose register result arrives only after the memory stage.
  function automatic logic late_result(input icode_t ic);
    return (ic == IC_LOAD) || (ic == IC_POP);
  endfunction

  // A real destination register feeding one of the two decode sources.
  function automatic logic src_hit(input reg_t dst, input reg_t a, input reg_t b);
    return (dst != REG_NONE) && ((dst == a) || (dst == b));
  endfunction

  // External view of the write-back status: an empty slot reads as OK.
  function automatic stat_t visible_stat(input stat_t s);
    return (s == ST_EMPTY) ? ST_OK : s;
  endfunction
endpackage

// File: rtl/hz_detect.sv
module hz_detect
  import hz_pkg::*;
(
  input  logic   clk,
  input  logic   rst_n,
  input  icode_t d_icode,
  input  icode_t e_icode,
  input  icode_t m_icode,
  input  reg_t   e_dst,
  input  reg_t   src_a,
  input  reg_t   src_b,
  input  logic   e_cond,
  input  stat_t  m_stat_now,
  input  stat_t  w_stat,
  output logic   f_stall,
  output logic   d_stall,
  output logic   d_bubble,
  output logic   e_bubble,
  output logic   m_bubble,
  output logic   w_stall,
  output logic   cc_en
);
  // Named hazard events, visible to the assertions below.
  logic lu_hit;
  logic ret_busy;
  logic mispredict;
  logic fault_m;
  logic fault_w;

  assign lu_hit     = late_result(e_icode) && src_hit(e_dst, src_a, src_b);
  assign ret_busy   = (d_icode == IC_RET) || (e_icode == IC_RET) || (m_icode == IC_RET);
  assign mispredict = (e_icode == IC_JUMP) && !e_cond;
  assign fault_m    = is_fault(m_stat_now);
  assign fault_w    = is_fault(w_stat);

  assign f_stall  = lu_hit || ret_busy;
  assign d_stall  = lu_hit;
  assign d_bubble = mispredict || (ret_busy && !lu_hit);
  assign e_bubble = mispredict || lu_hit;
  assign m_bubble = fault_m || fault_w;
  assign w_stall  = fault_w;
  assign cc_en    = (e_icode == IC_ALU) && !fault_m && !fault_w;

  p_loaduse_r1: assert property (@(posedge clk) disable iff (!rst_n)
    (late_result(e_icode) && e_dst != REG_NONE && (e_dst == src_a || e_dst == src_b))
      |-> (f_stall && d_stall && e_bubble));

  p_return_r2: assert property (@(posedge clk) disable iff (!rst_n)
    ((d_icode == IC_RET || m_icode == IC_RET) && !lu_hit) |-> (f_stall && d_bubble));

  p_mispredict_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (e_icode == IC_JUMP && !e_cond) |-> (d_bubble && e_bubble && !d_stall));

  p_priority_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (lu_hit && ret_busy) |-> (d_stall && !d_bubble));

  p_fault_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (is_fault(m_stat_now) || is_fault(w_stat)) |-> (m_bubble && !cc_en));

  p_cc_r6: assert property (@(posedge clk) disable iff (!rst_n)
    cc_en |-> (e_icode == IC_ALU && !m_bubble));

  p_excl_r12: assert property (@(posedge clk) disable iff (!rst_n)
    !(d_stall && d_bubble));
endmodule

// File: rtl/hz_stage_reg.sv
module hz_stage_reg #(
  parameter int               WIDTH      = 8,
  parameter logic [WIDTH-1:0] CLEAR_VAL  = '0,
  parameter bit               HAS_BUBBLE = 1'b1
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             stall,
  input  logic             bubble,
  input  logic [WIDTH-1:0] d,
  output logic [WIDTH-1:0] q
);
  logic take_clear;
  assign take_clear = HAS_BUBBLE && bubble;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)          q <= CLEAR_VAL;
    else if (take_clear) q <= CLEAR_VAL;
    else if (!stall)     q <= d;
  end

  p_hold_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (stall && !bubble) |=> (q == $past(q)));

  p_normal_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (!stall && !bubble) |=> (q == $past(d)));

  p_excl_r12: assert property (@(posedge clk) disable iff (!rst_n)
    !(stall && bubble));

  if (HAS_BUBBLE) begin : g_clear_check
    p_clear_r8: assert property (@(posedge clk) disable iff (!rst_n)
      bubble |=> (q == CLEAR_VAL));
  end
endmodule

// File: rtl/hz_pipe_ctrl.sv
module hz_pipe_ctrl
  import hz_pkg::*;
#(
  parameter int                DATA_W   = 64,
  parameter int                ADDR_W   = 64,
  parameter logic [ADDR_W-1:0] RESET_PC = '0,
  localparam int               STAGE_W  = ST_W + IC_W + RG_W + DATA_W
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic [ADDR_W-1:0]  f_in,
  output logic [ADDR_W-1:0]  f_q,
  input  logic [STAGE_W-1:0] d_in,
  output logic [STAGE_W-1:0] d_q,
  input  logic [STAGE_W-1:0] e_in,
  output logic [STAGE_W-1:0] e_q,
  input  logic [STAGE_W-1:0] m_in,
  output logic [STAGE_W-1:0] m_q,
  input  logic [STAGE_W-1:0] w_in,
  output logic [STAGE_W-1:0] w_q,
  input  logic [RG_W-1:0]    dec_src_a,
  input  logic [RG_W-1:0]    dec_src_b,
  input  logic               exe_cond,
  input  logic [ST_W-1:0]    mem_stat,
  output logic               f_stall,
  output logic               d_stall,
  output logic               d_bubble,
  output logic               e_bubble,
  output logic               m_bubble,
  output logic               w_stall,
  output logic               cc_write_en,
  output logic [ST_W-1:0]    out_stat
);
  localparam int NSTG   = 4;
  localparam int ST_LSB = STAGE_W - ST_W;
  localparam int IC_LSB = ST_LSB - IC_W;
  localparam int RG_LSB = IC_LSB - RG_W;
  localparam logic [STAGE_W-1:0] STAGE_CLEAR = {ST_EMPTY, IC_NOP, REG_NONE, {DATA_W{1'b0}}};

  function automatic stat_t fld_stat(input logic [STAGE_W-1:0] v);
    return v[ST_LSB +: ST_W];
  endfunction
  function automatic icode_t fld_icode(input logic [STAGE_W-1:0] v);
    return v[IC_LSB +: IC_W];
  endfunction
  function automatic reg_t fld_dst(input logic [STAGE_W-1:0] v);
    return v[RG_LSB +: RG_W];
  endfunction

  // Stage index: 0 decode, 1 execute, 2 memory, 3 write-back.
  logic [STAGE_W-1:0] stg_in  [NSTG];
  logic [STAGE_W-1:0] stg_q   [NSTG];
  logic               stg_stl [NSTG];
  logic               stg_bub [NSTG];

  assign stg_in[0] = d_in;
  assign stg_in[1] = e_in;
  assign stg_in[2] = m_in;
  assign stg_in[3] = w_in;
  assign d_q = stg_q[0];
  assign e_q = stg_q[1];
  assign m_q = stg_q[2];
  assign w_q = stg_q[3];

  stat_t w_stat;
  assign w_stat = fld_stat(stg_q[3]);

  hz_detect u_detect (
    .clk        (clk),
    .rst_n      (rst_n),
    .d_icode    (fld_icode(stg_q[0])),
    .e_icode    (fld_icode(stg_q[1])),
    .m_icode    (fld_icode(stg_q[2])),
    .e_dst      (fld_dst(stg_q[1])),
    .src_a      (dec_src_a),
    .src_b      (dec_src_b),
    .e_cond     (exe_cond),
    .m_stat_now (mem_stat),
    .w_stat     (w_stat),
    .f_stall    (f_stall),
    .d_stall    (d_stall),
    .d_bubble   (d_bubble),
    .e_bubble   (e_bubble),
    .m_bubble   (m_bubble),
    .w_stall    (w_stall),
    .cc_en      (cc_write_en)
  );

  // Execute and memory never hold; write-back is never cleared.
  assign stg_stl[0] = d_stall;
  assign stg_stl[1] = 1'b0;
  assign stg_stl[2] = 1'b0;
  assign stg_stl[3] = w_stall;
  assign stg_bub[0] = d_bubble;
  assign stg_bub[1] = e_bubble;
  assign stg_bub[2] = m_bubble;
  assign stg_bub[3] = 1'b0;

  for (genvar g = 0; g < NSTG; g++) begin : g_stage
    hz_stage_reg #(
      .WIDTH      (STAGE_W),
      .CLEAR_VAL  (STAGE_CLEAR),
      .HAS_BUBBLE (1'b1)
    ) u_reg (
      .clk    (clk),
      .rst_n  (rst_n),
      .stall  (stg_stl[g]),
      .bubble (stg_bub[g]),
      .d      (stg_in[g]),
      .q      (stg_q[g])
    );
  end

  hz_stage_reg #(
    .WIDTH      (ADDR_W),
    .CLEAR_VAL  (RESET_PC),
    .HAS_BUBBLE (1'b0)
  ) u_fetch (
    .clk    (clk),
    .rst_n  (rst_n),
    .stall  (f_stall),
    .bubble (1'b0),
    .d      (f_in),
    .q      (f_q)
  );

  assign out_stat = visible_stat(w_stat);

  p_outstat_r11: assert property (@(posedge clk) disable iff (!rst_n)
    (out_stat != ST_EMPTY) && ((w_stat == ST_EMPTY) ? (out_stat == ST_OK) : (out_stat == w_stat)));

  p_wfreeze_r5: assert property (@(posedge clk) disable iff (!rst_n)
    is_fault(w_stat) |=> $stable(w_q));
endmodule

// File: tb/hz_pipe_ctrl_test.sv
module hz_pipe_ctrl_test;
  localparam int DW = 16;
  localparam int AW = 16;
  localparam int SW = 3 + 4 + 4 + DW;
  localparam logic [AW-1:0] RPC = 16'h0100;
  localparam logic [SW-1:0] CLR = {3'd0, 4'd1, 4'd15, {DW{1'b0}}};

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic [AW-1:0] f_in, f_q;
  logic [SW-1:0] d_in, d_q, e_in, e_q, m_in, m_q, w_in, w_q;
  logic [3:0] dec_src_a, dec_src_b;
  logic exe_cond;
  logic [2:0] mem_stat, out_stat;
  logic f_stall, d_stall, d_bubble, e_bubble, m_bubble, w_stall, cc_write_en;

  always #10 clk = ~clk;

  hz_pipe_ctrl #(.DATA_W(DW), .ADDR_W(AW), .RESET_PC(RPC)) uut (
    .clk(clk), .rst_n(rst_n), .f_in(f_in), .f_q(f_q),
    .d_in(d_in), .d_q(d_q), .e_in(e_in), .e_q(e_q),
    .m_in(m_in), .m_q(m_q), .w_in(w_in), .w_q(w_q),
    .dec_src_a(dec_src_a), .dec_src_b(dec_src_b), .exe_cond(exe_cond),
    .mem_stat(mem_stat), .f_stall(f_stall), .d_stall(d_stall),
    .d_bubble(d_bubble), .e_bubble(e_bubble), .m_bubble(m_bubble),
    .w_stall(w_stall), .cc_write_en(cc_write_en), .out_stat(out_stat)
  );

  int nchk = 0;
  int nfail = 0;
  bit done = 1'b0;
  logic [SW-1:0] mq [4];
  logic [AW-1:0] mpc;
  int last_act [4];

  function automatic logic [SW-1:0] mk(input logic [2:0] s, input logic [3:0] ic,
                                       input logic [3:0] r, input logic [DW-1:0] dat);
    return {s, ic, r, dat};
  endfunction
  function automatic logic [2:0] st_of(input logic [SW-1:0] v); return v[SW-1 -: 3]; endfunction
  function automatic logic [3:0] ic_of(input logic [SW-1:0] v); return v[SW-4 -: 4]; endfunction
  function automatic logic [3:0] rg_of(input logic [SW-1:0] v); return v[SW-8 -: 4]; endfunction
  function automatic logic bad(input logic [2:0] s); return s inside {3'd2, 3'd3, 3'd4}; endfunction

  function automatic logic [SW-1:0] rnd_stage(input int fault_pct);
    int r;
    logic [2:0] s;
    r = $urandom_range(0, 99);
    if (r < fault_pct) s = 3'($urandom_range(2, 4));
    else if (r < fault_pct + 10) s = 3'd0;
    else s = 3'd1;
    return mk(s, 4'($urandom_range(0, 11)),
              ($urandom_range(0, 4) == 0) ? 4'd15 : 4'($urandom_range(0, 5)),
              DW'($urandom));
  endfunction

  task automatic chk(input string req, input string what, input logic [63:0] act, input logic [63:0] exp);
    nchk++;
    if (act !== exp) begin
      nfail++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
    end
  endtask

  task automatic idle();
    f_in = 16'($urandom);
    d_in = mk(3'd1, 4'd1, 4'd15, '0);
    e_in = d_in; m_in = d_in; w_in = d_in;
    dec_src_a = 4'd15; dec_src_b = 4'd15;
    exe_cond = 1'b1; mem_stat = 3'd1;
  endtask

  task automatic rnd_inputs();
    f_in = 16'($urandom);
    d_in = rnd_stage(10); e_in = rnd_stage(10); m_in = rnd_stage(10); w_in = rnd_stage(2);
    dec_src_a = ($urandom_range(0, 3) == 0) ? 4'd15 : 4'($urandom_range(0, 5));
    dec_src_b = ($urandom_range(0, 3) == 0) ? 4'd15 : 4'($urandom_range(0, 5));
    exe_cond = 1'($urandom);
    mem_stat = ($urandom_range(0, 9) == 0) ? 3'($urandom_range(2, 4)) : 3'd1;
  endtask

  // Called just after a falling edge, with inputs already set.
  task automatic step();
    logic lu, rb, mp, fm, fw, xfs, xds, xdb, xeb, xmb, xws, xcc;
    logic [SW-1:0] ins [4];
    logic [SW-1:0] qs [4];
    logic [SW-1:0] nx [4];
    logic st [4];
    logic bb [4];
    #2;
    ins = '{d_in, e_in, m_in, w_in};
    qs = '{d_q, e_q, m_q, w_q};
    for (int i = 0; i < 4; i++) begin
      case (last_act[i])
        1: chk("R7", $sformatf("held stage %0d", i), 64'(qs[i]), 64'(mq[i]));
        2: chk("R8", $sformatf("cleared stage %0d", i), 64'(qs[i]), 64'(mq[i]));
        3: chk("R10", $sformatf("reset stage %0d", i), 64'(qs[i]), 64'(mq[i]));
        default: chk("R9", $sformatf("loaded stage %0d", i), 64'(qs[i]), 64'(mq[i]));
      endcase
    end
    chk("R7_R9", "fetch address", 64'(f_q), 64'(mpc));

    lu = 1'b0;
    if ((ic_of(mq[1]) == 4'd5 || ic_of(mq[1]) == 4'd11) && rg_of(mq[1]) != 4'd15)
      lu = (rg_of(mq[1]) == dec_src_a) || (rg_of(mq[1]) == dec_src_b);
    rb = (ic_of(mq[0]) == 4'd9) || (ic_of(mq[1]) == 4'd9) || (ic_of(mq[2]) == 4'd9);
    mp = (ic_of(mq[1]) == 4'd7) && !exe_cond;
    fm = bad(mem_stat);
    fw = bad(st_of(mq[3]));
    xfs = lu | rb;
    xds = lu;
    xdb = mp | (rb & ~lu);
    xeb = mp | lu;
    xmb = fm | fw;
    xws = fw;
    xcc = (ic_of(mq[1]) == 4'd6) && !fm && !fw;

    chk("R2", "f_stall", 64'(f_stall), 64'(xfs));
    chk("R1", "d_stall", 64'(d_stall), 64'(xds));
    chk("R3", "d_bubble", 64'(d_bubble), 64'(xdb));
    chk("R1", "e_bubble", 64'(e_bubble), 64'(xeb));
    chk("R5", "m_bubble", 64'(m_bubble), 64'(xmb));
    chk("R5", "w_stall", 64'(w_stall), 64'(xws));
    chk("R6", "cc_write_en", 64'(cc_write_en), 64'(xcc));
    chk("R12", "decode stall with bubble", 64'(d_stall & d_bubble), 64'd0);
    chk("R11", "out_stat", 64'(out_stat),
        64'((st_of(mq[3]) == 3'd0) ? 3'd1 : st_of(mq[3])));

    st = '{xds, 1'b0, 1'b0, xws};
    bb = '{xdb, xeb, xmb, 1'b0};
    for (int i = 0; i < 4; i++) begin
      if (bb[i]) begin nx[i] = CLR; last_act[i] = 2; end
      else if (st[i]) begin nx[i] = mq[i]; last_act[i] = 1; end
      else begin nx[i] = ins[i]; last_act[i] = 0; end
    end
    @(posedge clk);
    #1;
    for (int i = 0; i < 4; i++) mq[i] = nx[i];
    if (!xfs) mpc = f_in;
    @(negedge clk);
  endtask

  task automatic do_reset();
    rst_n = 1'b0;
    @(negedge clk);
    @(negedge clk);
    #2;
    chk("R10", "reset decode", 64'(d_q), 64'(CLR));
    chk("R10", "reset execute", 64'(e_q), 64'(CLR));
    chk("R10", "reset memory", 64'(m_q), 64'(CLR));
    chk("R10", "reset write-back", 64'(w_q), 64'(CLR));
    chk("R10", "reset fetch", 64'(f_q), 64'(RPC));
    rst_n = 1'b1;
    for (int i = 0; i < 4; i++) begin mq[i] = CLR; last_act[i] = 3; end
    mpc = RPC;
  endtask

  initial begin
    void'($urandom(32'd7731));
    idle();
    do_reset();
    #1;
    chk("R11", "empty write-back reads OK", 64'(out_stat), 64'd1);

    // Load in execute feeding decode while a return sits in decode.
    idle(); d_in = mk(3'd1, 4'd9, 4'd15, '0); e_in = mk(3'd1, 4'd5, 4'd4, 16'h0055);
    step();
    idle(); dec_src_a = 4'd4;
    #2;
    chk("R4", "decode stalls under load/use plus return", 64'(d_stall), 64'd1);
    chk("R4", "decode not cleared", 64'(d_bubble), 64'd0);
    chk("R1", "execute cleared", 64'(e_bubble), 64'd1);
    step();
    idle(); step(); idle(); step(); idle(); step();

    // Load whose destination is the none register never matches.
    idle(); e_in = mk(3'd1, 4'd11, 4'd15, '0);
    step();
    idle(); dec_src_a = 4'd15;
    #2;
    chk("R1", "none register does not stall", 64'(d_stall), 64'd0);
    step();

    // Return in memory only.
    idle(); m_in = mk(3'd1, 4'd9, 4'd15, '0);
    step();
    idle();
    #2;
    chk("R2", "return in memory stalls fetch", 64'(f_stall), 64'd1);
    chk("R2", "return in memory clears decode", 64'(d_bubble), 64'd1);
    step(); idle(); step();

    // Not-taken jump in execute.
    idle(); e_in = mk(3'd1, 4'd7, 4'd15, '0);
    step();
    idle(); exe_cond = 1'b0;
    #2;
    chk("R3", "decode cleared", 64'(d_bubble), 64'd1);
    chk("R3", "execute cleared", 64'(e_bubble), 64'd1);
    chk("R3", "fetch runs", 64'(f_stall), 64'd0);
    step();

    // Condition flag gating by memory status.
    idle(); e_in = mk(3'd1, 4'd6, 4'd2, '0);
    step();
    idle(); mem_stat = 3'd3;
    #2;
    chk("R5", "flags blocked on address error", 64'(cc_write_en), 64'd0);
    chk("R5", "memory cleared on fault", 64'(m_bubble), 64'd1);
    mem_stat = 3'd1;
    #1;
    chk("R6", "flags enabled for arithmetic", 64'(cc_write_en), 64'd1);
    step();

    // Halt reaching write-back freezes it.
    idle(); w_in = mk(3'd2, 4'd0, 4'd15, 16'h00aa);
    step();
    idle();
    #2;
    chk("R11", "write-back halt reported", 64'(out_stat), 64'd2);
    chk("R5", "write-back frozen", 64'(w_stall), 64'd1);
    step(); idle(); step();
    do_reset();

    for (int n = 0; n < 3000; n++) begin
      if (n % 60 == 59) do_reset();
      rnd_inputs();
      step();
    end

    if (!done) begin
      done = 1'b1;
      $display("%0d/%0d checks passed", nchk - nfail, nchk);
      $finish;
    end
  end

  initial begin
    #(20 * 200000);
    if (!done) begin
      done = 1'b1;
      nchk++;
      nfail++;
      $display("FAIL watchdog: actual running expected finished");
      $display("%0d/%0d checks passed", nchk - nfail, nchk);
      $finish;
    end
  end
endmodule